// File: doc/BRIEF.md
# Serial Receive Byte Queue with Threshold Flag

This block buffers bytes that a serial receiver has already deserialized. Bytes enter through a push port. They leave in arrival order through either a processor read strobe or a separate DMA read strobe. The number of bytes currently held is shown on a count output whose upper bits are zero.

A status flag tells software or a DMA engine that enough bytes have arrived. A two-bit selector picks the threshold. The flag rises as soon as the held count reaches that threshold.

Lowering the flag is deliberately hard:
- Software must first read the flag while it is 1, and then write 0 to it.
- Alternatively, DMA reads must take the count below the threshold.
- In both cases the clear only takes effect once the count has dropped under the threshold.

Plain processor reads never lower the flag on their own. A push into a full queue is discarded and sets a sticky overflow indication.

Top module: `rx_trig_fifo`

## Requirements
- R1: The queue stores up to 16 bytes and returns them in arrival order. A read accepted at a clock edge (cpu_rd or dma_rd high, queue not empty) presents its byte on rd_data right after that edge. A simultaneous cpu_rd and dma_rd removes only one byte.
- R2: fill_cnt holds the number of stored bytes after each edge, in bits 7:0 with unused upper bits zero.
- R3: A push when 16 bytes are held and no read is accepted in the same cycle is discarded. fill_cnt stays at 16 and ovf_sticky becomes 1 and stays 1 until reset.
- R4: A read while the queue is empty leaves fill_cnt unchanged and does not disturb the order of later data. rd_data is undefined in that case.
- R5: thr_sel encodes the threshold as 00=1, 01=4, 10=8, 11=14 bytes. At every edge where the updated count is at or above the selected threshold, rdy_flag is 1 after the edge.
- R6: Synchronous active-high rst clears rdy_flag, fill_cnt and ovf_sticky to 0.
- R7: flg_rd while rdy_flag is 1 arms a software clear. A later flg_wr with flg_wdata=0 clears rdy_flag only if armed and the updated count is below the threshold. Any flg_wr cancels the arming. Writing 1 never changes the flag, and writing 0 without arming is ignored.
- R8: A DMA read that is accepted and leaves the count below the threshold clears rdy_flag with no software write.
- R9: Processor reads alone, with no flag write and no DMA read, never clear rdy_flag.
- R10: A push and an accepted read in the same cycle leave fill_cnt unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_vld | input | 1 | Byte from receiver is valid this cycle |
| push_data | input | 8 | Received byte |
| cpu_rd | input | 1 | Processor read strobe |
| dma_rd | input | 1 | DMA read strobe |
| rd_data | output | 8 | Byte removed at the last accepted read |
| thr_sel | input | 2 | Threshold selector |
| flg_rd | input | 1 | Software reads the flag this cycle |
| flg_wr | input | 1 | Software writes the flag this cycle |
| flg_wdata | input | 1 | Value written to the flag |
| rdy_flag | output | 1 | Threshold-reached flag |
| fill_cnt | output | 8 | Stored byte count |
| ovf_sticky | output | 1 | A push was dropped since reset |

## Verification
Each internal state of this block is visible on a port one edge later:
- A pointer that skips or repeats shows up on rd_data at the very next accepted read.
- A count that drifts shows up on fill_cnt at the edge where it goes wrong.
- A bad flag rule shows up on rdy_flag at the edge where set or clear should have been decided.

Because of this, a per-edge comparison against a queue-based model exposes most faults within one cycle. The arming state is hidden, so an error in it shows only at the next flag write. The handshake sequences therefore place writes directly after, and well after, flag reads.

// File: rtl/rx_trig_pkg.sv
package rx_trig_pkg;
  localparam int unsigned THR_W = 5;

  function automatic logic [THR_W-1:0] thr_count(input logic [1:0] sel);
    case (sel)
      2'd0:    thr_count = 5'd1;
      2'd1:    thr_count = 5'd4;
      2'd2:    thr_count = 5'd8;
      default: thr_count = 5'd14;
    endcase
  endfunction
endpackage

// File: rtl/rx_trig_mem.sv
module rx_trig_mem #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= store[rd_addr];
  end
endmodule

// File: rtl/rx_trig_ctrl.sv
module rx_trig_ctrl #(
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_vld,
  input  logic             pop_req,
  output logic             push_ok,
  output logic             pop_ok,
  output logic [AW-1:0]    wptr,
  output logic [AW-1:0]    rptr,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             ovf
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [AW-1:0]    LAST_IDX = AW'(DEPTH - 1);

  always_comb begin
    pop_ok  = pop_req && (cnt != '0);
    push_ok = push_vld && ((cnt != FULL_CNT) || pop_ok);
    cnt_nxt = cnt;
    if (push_ok && !pop_ok) cnt_nxt = cnt + 1'b1;
    if (pop_ok && !push_ok) cnt_nxt = cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      wptr <= '0;
      rptr <= '0;
      ovf  <= 1'b0;
    end else begin
      cnt <= cnt_nxt;
      if (push_ok) wptr <= (wptr == LAST_IDX) ? '0 : wptr + 1'b1;
      if (pop_ok)  rptr <= (rptr == LAST_IDX) ? '0 : rptr + 1'b1;
      if (push_vld && !push_ok) ovf <= 1'b1;
    end
  end
endmodule

// File: rtl/rx_trig_flag.sv
module rx_trig_flag #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic [1:0]       thr_sel,
  input  logic             dma_pop,
  input  logic             flg_rd,
  input  logic             flg_wr,
  input  logic             flg_wdata,
  output logic             flag
);
  logic             armed;
  logic [CNT_W-1:0] thr;
  logic             below;
  logic             sw_clr;
  logic             flag_nxt;

  always_comb begin
    thr    = CNT_W'(rx_trig_pkg::thr_count(thr_sel));
    below  = cnt_nxt < thr;
    sw_clr = flg_wr && !flg_wdata && armed;
    if (!below)                            flag_nxt = 1'b1;
    else if (sw_clr || dma_pop)            flag_nxt = 1'b0;
    else                                   flag_nxt = flag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag  <= 1'b0;
      armed <= 1'b0;
    end else begin
      flag <= flag_nxt;
      if (flg_wr)              armed <= 1'b0;
      else if (flg_rd && flag) armed <= 1'b1;
    end
  end
endmodule

// File: rtl/rx_trig_fifo.sv
module rx_trig_fifo #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CW    = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_vld,
  input  logic [DW-1:0] push_data,
  input  logic          cpu_rd,
  input  logic          dma_rd,
  output logic [DW-1:0] rd_data,
  input  logic [1:0]    thr_sel,
  input  logic          flg_rd,
  input  logic          flg_wr,
  input  logic          flg_wdata,
  output logic          rdy_flag,
  output logic [CW-1:0] fill_cnt,
  output logic          ovf_sticky
);
  localparam int unsigned AW    = $clog2(DEPTH);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic             push_ok, pop_ok;
  logic [AW-1:0]    wptr, rptr;
  logic [CNT_W-1:0] cnt, cnt_nxt;

  rx_trig_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .push_vld(push_vld), .pop_req(cpu_rd | dma_rd),
    .push_ok(push_ok), .pop_ok(pop_ok), .wptr(wptr), .rptr(rptr),
    .cnt(cnt), .cnt_nxt(cnt_nxt), .ovf(ovf_sticky)
  );

  rx_trig_mem #(.DW(DW), .DEPTH(DEPTH)) u_mem (
    .clk(clk), .wr_en(push_ok), .wr_addr(wptr), .wr_data(push_data),
    .rd_en(pop_ok), .rd_addr(rptr), .rd_data(rd_data)
  );

  rx_trig_flag #(.CNT_W(CNT_W)) u_flag (
    .clk(clk), .rst(rst), .cnt_nxt(cnt_nxt), .thr_sel(thr_sel),
    .dma_pop(dma_rd && pop_ok), .flg_rd(flg_rd), .flg_wr(flg_wr),
    .flg_wdata(flg_wdata), .flag(rdy_flag)
  );

  assign fill_cnt = CW'(cnt);
endmodule

// File: rtl/rx_trig_fifo_chk.sv
module rx_trig_fifo_chk #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CW    = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          push_vld,
  input logic          cpu_rd,
  input logic          dma_rd,
  input logic [1:0]    thr_sel,
  input logic          flg_wr,
  input logic          flg_wdata,
  input logic          rdy_flag,
  input logic [CW-1:0] fill_cnt,
  input logic          ovf_sticky
);
  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
    fill_cnt <= CW'(DEPTH));

  assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    ovf_sticky |=> ovf_sticky);

  assert_empty_read_R4: assert property (@(posedge clk) disable iff (rst)
    (fill_cnt == '0 && !push_vld && (cpu_rd || dma_rd)) |=> fill_cnt == '0);

  assert_push_pop_R10: assert property (@(posedge clk) disable iff (rst)
    (push_vld && (cpu_rd || dma_rd) && fill_cnt != '0) |=> $stable(fill_cnt));

  assert_flag_set_R5: assert property (@(posedge clk) disable iff (rst)
    (fill_cnt >= CW'(rx_trig_pkg::thr_count($past(thr_sel)))) |-> rdy_flag);

  assert_cpu_keep_R9: assert property (@(posedge clk) disable iff (rst)
    (rdy_flag && !flg_wr && !dma_rd) |=> rdy_flag);

  assert_write_one_R7: assert property (@(posedge clk) disable iff (rst)
    (rdy_flag && flg_wr && flg_wdata && !dma_rd) |=> rdy_flag);
endmodule

bind rx_trig_fifo rx_trig_fifo_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .push_vld(push_vld), .cpu_rd(cpu_rd), .dma_rd(dma_rd),
  .thr_sel(thr_sel), .flg_wr(flg_wr), .flg_wdata(flg_wdata),
  .rdy_flag(rdy_flag), .fill_cnt(fill_cnt), .ovf_sticky(ovf_sticky)
);

// File: tb/rx_trig_fifo_tb.sv
module rx_trig_fifo_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       push_vld = 1'b0;
  logic [7:0] push_data = '0;
  logic       cpu_rd = 1'b0, dma_rd = 1'b0;
  logic [7:0] rd_data;
  logic [1:0] thr_sel = 2'd1;
  logic       flg_rd = 1'b0, flg_wr = 1'b0, flg_wdata = 1'b0;
  logic       rdy_flag;
  logic [7:0] fill_cnt;
  logic       ovf_sticky;

  int total = 0;
  int bad   = 0;
  byte unsigned q[$];
  bit  m_flag = 0, m_arm = 0, m_ovf = 0;
  string cnt_tag  = "R2";
  string flag_tag = "R5";
  byte unsigned nxt_byte = 8'h10;

  always #5 clk = ~clk;

  rx_trig_fifo u_dut (
    .clk(clk), .rst(rst), .push_vld(push_vld), .push_data(push_data),
    .cpu_rd(cpu_rd), .dma_rd(dma_rd), .rd_data(rd_data), .thr_sel(thr_sel),
    .flg_rd(flg_rd), .flg_wr(flg_wr), .flg_wdata(flg_wdata),
    .rdy_flag(rdy_flag), .fill_cnt(fill_cnt), .ovf_sticky(ovf_sticky)
  );

  function automatic int thr_of(input logic [1:0] s);
    case (s)
      2'd0: return 1;
      2'd1: return 4;
      2'd2: return 8;
      default: return 14;
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input bit pv, input bit cr, input bit dr,
                      input bit fr, input bit fw, input bit fd);
    bit popd;
    bit old_arm;
    int c, t;
    byte unsigned exp_d;
    @(negedge clk);
    push_vld = pv; push_data = nxt_byte; cpu_rd = cr; dma_rd = dr;
    flg_rd = fr; flg_wr = fw; flg_wdata = fd;
    @(posedge clk);
    t = thr_of(thr_sel);
    popd = (cr || dr) && q.size() > 0;
    exp_d = 0;
    if (popd) exp_d = q.pop_front();
    if (pv) begin
      if (q.size() < 16) q.push_back(nxt_byte);
      else m_ovf = 1;
      nxt_byte = nxt_byte + 8'd7;
    end
    c = q.size();
    old_arm = m_arm;
    if (fw) m_arm = 0;
    else if (fr && m_flag) m_arm = 1;
    if (c >= t) m_flag = 1;
    else if ((fw && !fd && old_arm) || (dr && popd)) m_flag = 0;
    #1;
    check(cnt_tag, int'(fill_cnt), c);
    check(flag_tag, int'(rdy_flag), int'(m_flag));
    check("R3", int'(ovf_sticky), int'(m_ovf));
    if (popd) check("R1", int'(rd_data), int'(exp_d));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R6", int'(fill_cnt), 0);
    check("R6", int'(rdy_flag), 0);
    check("R6", int'(ovf_sticky), 0);

    thr_sel = 2'd1;
    flag_tag = "R5";
    for (int i = 0; i < 4; i++) step(1, 0, 0, 0, 0, 0);

    flag_tag = "R9";
    step(0, 1, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0, 0);

    flag_tag = "R7";
    step(0, 0, 0, 0, 1, 0);
    step(0, 0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 1, 1);
    step(0, 0, 0, 0, 1, 0);
    step(0, 0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 0);
    check("R7", int'(rdy_flag), 0);

    flag_tag = "R5";
    cnt_tag = "R3";
    for (int i = 0; i < 16; i++) step(1, 0, 0, 0, 0, 0);
    cnt_tag = "R10";
    step(1, 1, 0, 0, 0, 0);
    step(1, 0, 1, 0, 0, 0);

    flag_tag = "R7";
    step(0, 0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 1, 0);

    flag_tag = "R8";
    cnt_tag = "R2";
    thr_sel = 2'd3;
    step(0, 0, 1, 0, 0, 0);
    step(0, 0, 1, 0, 0, 0);
    step(0, 0, 1, 0, 0, 0);
    check("R8", int'(rdy_flag), 0);

    flag_tag = "R5";
    thr_sel = 2'd2;
    step(0, 0, 0, 0, 0, 0);
    check("R5", int'(rdy_flag), 1);

    cnt_tag = "R4";
    flag_tag = "R9";
    for (int i = 0; i < 14; i++) step(0, 1, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0, 0);
    step(0, 1, 1, 0, 0, 0);
    check("R4", int'(fill_cnt), 0);

    thr_sel = 2'd0;
    flag_tag = "R5";
    cnt_tag = "R1";
    step(1, 0, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0);
    cnt_tag = "R10";
    step(1, 1, 1, 0, 0, 0);
    step(0, 1, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0, 0);

    cnt_tag = "R2";
    flag_tag = "R7";
    for (int i = 0; i < 400; i++) begin
      if (i % 50 == 0) thr_sel = 2'($urandom_range(0, 3));
      step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) == 0),
           1'($urandom_range(0, 4) == 0), 1'($urandom_range(0, 3) == 0),
           1'($urandom_range(0, 5) == 0), 1'($urandom_range(0, 2) == 0));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule